// File: doc/BRIEF.md
# Calendar Time Snapshot Sequencer

This block turns whole-time requests from a host into the short run of register transactions that a serial real-time-clock device needs. It sits above a bit-serial register master. The master does the signalling on the wires. This block decides which register to touch, in which order, and with which data.

A read of the time first commands the device to freeze its running clock into a set of holding registers. It then reads the seven calendar fields one after another and converts each from packed BCD into binary. A write of the time goes the other way. The block converts seven binary fields into BCD, writes them into the holding registers, and then commands the device to load them into its running clock.

A start-up probe does three things. It puts the device's bit counter back in step, checks with a write and a read-back that the device answers, and then clears the device's mode register. Only one sequence runs at a time.

Top module: `rtc_snap_seq`

## Requirements
- R1: A get request issues a command to address 0xE (clock to holding, op code 2, write data 0). It then issues seven reads (op code 0) at addresses 0x0 to 0x6: seconds, minutes, hours, day of month, month, weekday, year, in that order.
- R2: A set request issues seven writes (op code 1) to addresses 0x0 to 0x6 in the same field order. It then issues a command to address 0xF (holding to clock, op code 2).
- R3: Read data is decoded as two BCD digits, tens in bits 7:4 and ones in bits 3:0. The month output is the decoded value minus one. The year output is the decoded value plus 100. Every other field is the decoded value.
- R4: Write data is the BCD form of the field, tens in bits 7:4. Month is written as the input plus one. Year is written as the input modulo 100. The set-time inputs are captured when the request is accepted, so later changes on those inputs have no effect on the sequence.
- R5: A read byte with a nibble above 9 is passed to its output unchanged, with no month or year adjustment. A binary field above 99 after adjustment is written unchanged. Either case sets conv_err_o, which is cleared when the next sequence is accepted.
- R6: A probe request issues one resync transaction (op code 3), then writes 0x33 to address 0x0, then reads address 0x0. When the read returns 0x33, the probe writes 0x00 to address 0x8 and clears dev_absent_o.
- R7: When the probe read-back differs from 0x33, the sequence ends at once and dev_absent_o is set. No status write is issued.
- R8: While busy_o is high, new requests are ignored. In idle, simultaneous requests are served in the order probe, then set, then get. busy_o rises only in the cycle after a request is accepted.
- R9: sm_req_o stays high, with sm_op_o, sm_addr_o and sm_wdata_o stable, until sm_ack_i is seen. A command or resync carries write data 0.
- R10: After reset, busy_o, done_o, sm_req_o, dev_absent_o, conv_err_o and all field outputs are 0. done_o is a single-cycle pulse in the cycle after the last transaction's acknowledge, with busy_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| get_req_i | input | 1 | Request a time read |
| set_req_i | input | 1 | Request a time write |
| probe_req_i | input | 1 | Request the start-up probe |
| sec_i | input | 8 | Seconds to write, binary |
| min_i | input | 8 | Minutes to write, binary |
| hour_i | input | 8 | Hours to write, binary |
| mday_i | input | 8 | Day of month to write, binary |
| mon_i | input | 8 | Month to write, zero-based binary |
| wday_i | input | 8 | Weekday to write, binary |
| year_i | input | 8 | Host year to write, binary |
| busy_o | output | 1 | A sequence is running |
| done_o | output | 1 | One-cycle pulse at the end of a sequence |
| dev_absent_o | output | 1 | Last probe failed its read-back |
| conv_err_o | output | 1 | A field failed BCD conversion in the last sequence |
| sec_o | output | 8 | Seconds read, binary |
| min_o | output | 8 | Minutes read, binary |
| hour_o | output | 8 | Hours read, binary |
| mday_o | output | 8 | Day of month read, binary |
| mon_o | output | 8 | Month read, zero-based binary |
| wday_o | output | 8 | Weekday read, binary |
| year_o | output | 8 | Host year read, binary |
| sm_req_o | output | 1 | Transaction request to the serial master |
| sm_op_o | output | 2 | Operation: 0 read, 1 write, 2 command, 3 resync |
| sm_addr_o | output | 4 | Register or command address |
| sm_wdata_o | output | 8 | Write data |
| sm_ack_i | input | 1 | One-cycle acknowledge from the master |
| sm_rdata_i | input | 8 | Read data, valid with the acknowledge |

## Verification
A request is accepted at the edge where it is high, and busy_o and the first transaction appear one edge later. Each step moves on at the edge where its acknowledge is seen, and the next transaction appears in the following cycle. The field outputs, dev_absent_o, conv_err_o and done_o all settle at the edge of the final acknowledge. The bench's serial-master model drives and samples only on falling edges. It polls done_o on falling edges and reads every result in the cycle done_o is seen, then checks one falling edge later that the pulse has gone.

// File: rtl/rtc_seq_pkg.sv
package rtc_seq_pkg;
    localparam int BYTE_W     = 8;
    localparam int NUM_FIELDS = 7;
    localparam int FIDX_W     = 3;
    localparam int STEP_W     = 3;

    // field slots, in transfer order
    localparam logic [FIDX_W-1:0] F_SEC  = 3'd0;
    localparam logic [FIDX_W-1:0] F_MIN  = 3'd1;
    localparam logic [FIDX_W-1:0] F_HOUR = 3'd2;
    localparam logic [FIDX_W-1:0] F_MDAY = 3'd3;
    localparam logic [FIDX_W-1:0] F_MON  = 3'd4;
    localparam logic [FIDX_W-1:0] F_WDAY = 3'd5;
    localparam logic [FIDX_W-1:0] F_YEAR = 3'd6;

    typedef enum logic [1:0] {
        OP_READ   = 2'd0,
        OP_WRITE  = 2'd1,
        OP_CMD    = 2'd2,
        OP_RESYNC = 2'd3
    } sm_op_e;

    typedef enum logic [1:0] {
        JOB_GET   = 2'd0,
        JOB_SET   = 2'd1,
        JOB_PROBE = 2'd2
    } job_e;

    typedef enum logic [1:0] {
        WS_NONE    = 2'd0,
        WS_FIELD   = 2'd1,
        WS_PATTERN = 2'd2,
        WS_ZERO    = 2'd3
    } wsrc_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } st_e;

    typedef struct packed {
        st_e                                st;
        job_e                               job;
        logic [STEP_W-1:0]                  step;
        logic [NUM_FIELDS-1:0][BYTE_W-1:0]  wf;
        logic [NUM_FIELDS-1:0][BYTE_W-1:0]  rf;
        logic                               done;
        logic                               absent;
        logic                               err;
    } seq_t;
endpackage

// File: rtl/rtc_bin2bcd.sv
module rtc_bin2bcd
    import rtc_seq_pkg::*;
(
    input  logic [BYTE_W-1:0] bin_i,
    output logic [BYTE_W-1:0] bcd_o,
    output logic              bad_o
);
    logic [3:0] tens;
    logic [3:0] ones;

    always_comb begin
        bad_o = (bin_i > 8'd99);
        tens  = 4'(bin_i / 8'd10);
        ones  = 4'(bin_i % 8'd10);
        bcd_o = bad_o ? bin_i : {tens, ones};
    end
endmodule

// File: rtl/rtc_bcd2bin.sv
module rtc_bcd2bin
    import rtc_seq_pkg::*;
(
    input  logic [BYTE_W-1:0] bcd_i,
    output logic [BYTE_W-1:0] bin_o,
    output logic              bad_o
);
    always_comb begin
        bad_o = (bcd_i[7:4] > 4'd9) || (bcd_i[3:0] > 4'd9);
        bin_o = bad_o ? bcd_i
                      : (({4'd0, bcd_i[7:4]} * 8'd10) + {4'd0, bcd_i[3:0]});
    end
endmodule

// File: rtl/rtc_seq_step.sv
module rtc_seq_step
    import rtc_seq_pkg::*;
#(
    parameter int               ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] A_SEC   = 4'h0,
    parameter logic [ADDR_W-1:0] A_MIN   = 4'h1,
    parameter logic [ADDR_W-1:0] A_HOUR  = 4'h2,
    parameter logic [ADDR_W-1:0] A_MDAY  = 4'h3,
    parameter logic [ADDR_W-1:0] A_MON   = 4'h4,
    parameter logic [ADDR_W-1:0] A_WDAY  = 4'h5,
    parameter logic [ADDR_W-1:0] A_YEAR  = 4'h6,
    parameter logic [ADDR_W-1:0] A_STAT  = 4'h8,
    parameter logic [ADDR_W-1:0] A_C2H   = 4'hE,
    parameter logic [ADDR_W-1:0] A_H2C   = 4'hF
) (
    input  job_e              job_i,
    input  logic [STEP_W-1:0] step_i,
    output sm_op_e            op_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [FIDX_W-1:0] fidx_o,
    output wsrc_e             wsrc_o,
    output logic              last_o,
    output logic              check_o
);
    localparam logic [NUM_FIELDS-1:0][ADDR_W-1:0] FADDR =
        {A_YEAR, A_WDAY, A_MON, A_MDAY, A_HOUR, A_MIN, A_SEC};
    localparam logic [STEP_W-1:0] LAST_FIELD_STEP = STEP_W'(NUM_FIELDS);

    always_comb begin
        op_o    = OP_READ;
        addr_o  = '0;
        fidx_o  = '0;
        wsrc_o  = WS_NONE;
        last_o  = 1'b0;
        check_o = 1'b0;
        case (job_i)
            JOB_GET: begin
                if (step_i == '0) begin
                    op_o   = OP_CMD;
                    addr_o = A_C2H;
                end else begin
                    fidx_o = step_i - 3'd1;
                    addr_o = FADDR[step_i - 3'd1];
                    last_o = (step_i == LAST_FIELD_STEP);
                end
            end
            JOB_SET: begin
                if (step_i == LAST_FIELD_STEP) begin
                    op_o   = OP_CMD;
                    addr_o = A_H2C;
                    last_o = 1'b1;
                end else begin
                    op_o   = OP_WRITE;
                    fidx_o = step_i;
                    addr_o = FADDR[step_i];
                    wsrc_o = WS_FIELD;
                end
            end
            JOB_PROBE: begin
                case (step_i)
                    3'd0: op_o = OP_RESYNC;
                    3'd1: begin
                        op_o   = OP_WRITE;
                        addr_o = A_SEC;
                        wsrc_o = WS_PATTERN;
                    end
                    3'd2: begin
                        addr_o  = A_SEC;
                        check_o = 1'b1;
                    end
                    default: begin
                        op_o   = OP_WRITE;
                        addr_o = A_STAT;
                        wsrc_o = WS_ZERO;
                        last_o = 1'b1;
                    end
                endcase
            end
            default: last_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/rtc_snap_seq.sv
module rtc_snap_seq
    import rtc_seq_pkg::*;
#(
    parameter int               ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] A_SEC    = 4'h0,
    parameter logic [ADDR_W-1:0] A_MIN    = 4'h1,
    parameter logic [ADDR_W-1:0] A_HOUR   = 4'h2,
    parameter logic [ADDR_W-1:0] A_MDAY   = 4'h3,
    parameter logic [ADDR_W-1:0] A_MON    = 4'h4,
    parameter logic [ADDR_W-1:0] A_WDAY   = 4'h5,
    parameter logic [ADDR_W-1:0] A_YEAR   = 4'h6,
    parameter logic [ADDR_W-1:0] A_STAT   = 4'h8,
    parameter logic [ADDR_W-1:0] A_C2H    = 4'hE,
    parameter logic [ADDR_W-1:0] A_H2C    = 4'hF,
    parameter logic [7:0]        PROBE_PAT = 8'h33,
    parameter int                YEAR_BASE = 100
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              get_req_i,
    input  logic              set_req_i,
    input  logic              probe_req_i,
    input  logic [7:0]        sec_i,
    input  logic [7:0]        min_i,
    input  logic [7:0]        hour_i,
    input  logic [7:0]        mday_i,
    input  logic [7:0]        mon_i,
    input  logic [7:0]        wday_i,
    input  logic [7:0]        year_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              dev_absent_o,
    output logic              conv_err_o,
    output logic [7:0]        sec_o,
    output logic [7:0]        min_o,
    output logic [7:0]        hour_o,
    output logic [7:0]        mday_o,
    output logic [7:0]        mon_o,
    output logic [7:0]        wday_o,
    output logic [7:0]        year_o,
    output logic              sm_req_o,
    output logic [1:0]        sm_op_o,
    output logic [ADDR_W-1:0] sm_addr_o,
    output logic [7:0]        sm_wdata_o,
    input  logic              sm_ack_i,
    input  logic [7:0]        sm_rdata_i
);
    localparam logic [BYTE_W-1:0] BASE1 = BYTE_W'(YEAR_BASE);
    localparam logic [BYTE_W-1:0] BASE2 = BYTE_W'(2 * YEAR_BASE);

    seq_t q, d;

    sm_op_e            st_op;
    logic [ADDR_W-1:0] st_addr;
    logic [FIDX_W-1:0] st_fidx;
    wsrc_e             st_wsrc;
    logic              st_last;
    logic              st_check;

    logic [BYTE_W-1:0] enc_in, enc_out, dec_out, rd_adj, yr_mod;
    logic              enc_bad, dec_bad;

    rtc_seq_step #(
        .ADDR_W(ADDR_W), .A_SEC(A_SEC), .A_MIN(A_MIN), .A_HOUR(A_HOUR),
        .A_MDAY(A_MDAY), .A_MON(A_MON), .A_WDAY(A_WDAY), .A_YEAR(A_YEAR),
        .A_STAT(A_STAT), .A_C2H(A_C2H), .A_H2C(A_H2C)
    ) u_step (
        .job_i   (q.job),
        .step_i  (q.step),
        .op_o    (st_op),
        .addr_o  (st_addr),
        .fidx_o  (st_fidx),
        .wsrc_o  (st_wsrc),
        .last_o  (st_last),
        .check_o (st_check)
    );

    rtc_bin2bcd u_enc (.bin_i(enc_in), .bcd_o(enc_out), .bad_o(enc_bad));
    rtc_bcd2bin u_dec (.bcd_i(sm_rdata_i), .bin_o(dec_out), .bad_o(dec_bad));

    // field adjustment around the shared converters
    always_comb begin
        yr_mod = q.wf[F_YEAR];
        if (yr_mod >= BASE2)      yr_mod = yr_mod - BASE2;
        else if (yr_mod >= BASE1) yr_mod = yr_mod - BASE1;

        if (st_fidx == F_MON)       enc_in = q.wf[F_MON] + 8'd1;
        else if (st_fidx == F_YEAR) enc_in = yr_mod;
        else                        enc_in = q.wf[st_fidx];

        if (dec_bad)                rd_adj = sm_rdata_i;
        else if (st_fidx == F_MON)  rd_adj = dec_out - 8'd1;
        else if (st_fidx == F_YEAR) rd_adj = dec_out + BASE1;
        else                        rd_adj = dec_out;
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (probe_req_i || set_req_i || get_req_i) begin
                    d.st   = ST_RUN;
                    d.step = '0;
                    d.err  = 1'b0;
                    if (probe_req_i) begin
                        d.job = JOB_PROBE;
                    end else if (set_req_i) begin
                        d.job = JOB_SET;
                        d.wf  = {year_i, wday_i, mon_i, mday_i, hour_i, min_i, sec_i};
                    end else begin
                        d.job = JOB_GET;
                    end
                end
            end
            default: begin
                if (sm_ack_i) begin
                    if (q.job == JOB_GET && st_op == OP_READ) begin
                        d.rf[st_fidx] = rd_adj;
                        if (dec_bad) d.err = 1'b1;
                    end
                    if (st_wsrc == WS_FIELD && enc_bad) d.err = 1'b1;
                    if (st_check && sm_rdata_i != PROBE_PAT) begin
                        d.absent = 1'b1;
                        d.st     = ST_IDLE;
                        d.done   = 1'b1;
                    end else begin
                        if (st_check) d.absent = 1'b0;
                        if (st_last) begin
                            d.st   = ST_IDLE;
                            d.done = 1'b1;
                        end else begin
                            d.step = q.step + 3'd1;
                        end
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    always_comb begin
        busy_o       = (q.st == ST_RUN);
        sm_req_o     = busy_o;
        sm_op_o      = st_op;
        sm_addr_o    = st_addr;
        case (st_wsrc)
            WS_FIELD:   sm_wdata_o = enc_out;
            WS_PATTERN: sm_wdata_o = PROBE_PAT;
            default:    sm_wdata_o = 8'h00;
        endcase
        done_o       = q.done;
        dev_absent_o = q.absent;
        conv_err_o   = q.err;
        sec_o        = q.rf[F_SEC];
        min_o        = q.rf[F_MIN];
        hour_o       = q.rf[F_HOUR];
        mday_o       = q.rf[F_MDAY];
        mon_o        = q.rf[F_MON];
        wday_o       = q.rf[F_WDAY];
        year_o       = q.rf[F_YEAR];
    end
endmodule

// File: rtl/rtc_snap_seq_chk.sv
module rtc_snap_seq_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              get_req_i,
    input logic              set_req_i,
    input logic              probe_req_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              dev_absent_o,
    input logic              sm_req_o,
    input logic [1:0]        sm_op_o,
    input logic [ADDR_W-1:0] sm_addr_o,
    input logic [7:0]        sm_wdata_o,
    input logic              sm_ack_i
);
    // R9: request and its fields held until acknowledged
    p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sm_req_o && !sm_ack_i) |=> (sm_req_o && $stable(sm_op_o)
                                     && $stable(sm_addr_o) && $stable(sm_wdata_o)));

    // R9: commands and resync carry zero data
    p_cmd_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sm_req_o && sm_op_o[1]) |-> (sm_wdata_o == 8'h00));

    // R10: done is a single-cycle pulse
    p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R10: done only while idle
    p_done_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o);

    // R8: a sequence starts only from an accepted request
    p_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> $past(get_req_i || set_req_i || probe_req_i));

    // R7: absence is raised only at the end of a sequence
    p_absent_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(dev_absent_o) |-> done_o);
endmodule

bind rtc_snap_seq rtc_snap_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .get_req_i    (get_req_i),
    .set_req_i    (set_req_i),
    .probe_req_i  (probe_req_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .dev_absent_o (dev_absent_o),
    .sm_req_o     (sm_req_o),
    .sm_op_o      (sm_op_o),
    .sm_addr_o    (sm_addr_o),
    .sm_wdata_o   (sm_wdata_o),
    .sm_ack_i     (sm_ack_i)
);

// File: tb/tb_rtc_snap_seq.sv
`timescale 1ns/100ps
module tb_rtc_snap_seq;
    localparam int LAT = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic get_req = 0, set_req = 0, probe_req = 0;
    logic [7:0] sec_i = 0, min_i = 0, hour_i = 0, mday_i = 0, mon_i = 0, wday_i = 0, year_i = 0;
    logic busy, done, absent, cerr;
    logic [7:0] sec_o, min_o, hour_o, mday_o, mon_o, wday_o, year_o;
    logic sm_req;
    logic [1:0] sm_op;
    logic [3:0] sm_addr;
    logic [7:0] sm_wdata;
    logic sm_ack = 0;
    logic [7:0] sm_rdata = 0;

    rtc_snap_seq dut (
        .clk_i(clk), .rst_ni(rst_n),
        .get_req_i(get_req), .set_req_i(set_req), .probe_req_i(probe_req),
        .sec_i(sec_i), .min_i(min_i), .hour_i(hour_i), .mday_i(mday_i),
        .mon_i(mon_i), .wday_i(wday_i), .year_i(year_i),
        .busy_o(busy), .done_o(done), .dev_absent_o(absent), .conv_err_o(cerr),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .mday_o(mday_o),
        .mon_o(mon_o), .wday_o(wday_o), .year_o(year_o),
        .sm_req_o(sm_req), .sm_op_o(sm_op), .sm_addr_o(sm_addr), .sm_wdata_o(sm_wdata),
        .sm_ack_i(sm_ack), .sm_rdata_i(sm_rdata)
    );

    int n_chk = 0, n_bad = 0;
    bit ended = 0;

    // device model state and transaction log
    logic [7:0] mem [16];
    logic [7:0] rclk [7];
    bit absent_mode = 0;
    int lop [32], laddr [32], ldata [32];
    int nlog = 0, hs_bad = 0, cnt = 0;
    logic [1:0] cap_op;
    logic [3:0] cap_addr;
    logic [7:0] cap_data;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // serial master model: acts on falling edges only
    initial begin
        forever begin
            @(negedge clk);
            if (sm_ack) begin
                sm_ack = 0;
                cnt = 0;
            end else if (sm_req) begin
                if (cnt == 0) begin
                    cap_op = sm_op; cap_addr = sm_addr; cap_data = sm_wdata;
                end else if (cap_op != sm_op || cap_addr != sm_addr || cap_data != sm_wdata) begin
                    hs_bad++;
                end
                if (cnt == LAT) begin
                    if (nlog < 32) begin
                        lop[nlog] = int'(sm_op); laddr[nlog] = int'(sm_addr);
                        ldata[nlog] = int'(sm_wdata); nlog++;
                    end
                    case (sm_op)
                        2'd0: sm_rdata = absent_mode ? 8'hFF : mem[sm_addr];
                        2'd1: mem[sm_addr] = sm_wdata;
                        2'd2: begin
                            if (sm_addr == 4'hE) for (int i = 0; i < 7; i++) mem[i] = rclk[i];
                            if (sm_addr == 4'hF) for (int i = 0; i < 7; i++) rclk[i] = mem[i];
                        end
                        default: ;
                    endcase
                    sm_ack = 1;
                end else begin
                    cnt++;
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        finish_run();
    end

    task automatic pulse(input bit g, input bit s, input bit p);
        @(negedge clk);
        get_req = g; set_req = s; probe_req = p;
        @(negedge clk);
        get_req = 0; set_req = 0; probe_req = 0;
    endtask

    // polls done at falling edges; the pulse must be gone one cycle later
    task automatic wait_done(input string tag);
        int n = 0;
        while (!done && n < 300) begin
            @(negedge clk);
            n++;
        end
        chk({tag, " R10 done seen"}, int'(done), 1);
        chk({tag, " R10 idle at done"}, int'(busy), 0);
    endtask

    task automatic done_gone(input string tag);
        @(negedge clk);
        chk({tag, " R10 done single pulse"}, int'(done), 0);
    endtask

    task automatic t_reset();
        chk("R10 busy at reset", int'(busy), 0);
        chk("R10 done at reset", int'(done), 0);
        chk("R10 req at reset", int'(sm_req), 0);
        chk("R10 absent at reset", int'(absent), 0);
        chk("R10 err at reset", int'(cerr), 0);
        chk("R10 sec at reset", int'(sec_o), 0);
        chk("R10 year at reset", int'(year_o), 0);
    endtask

    task automatic t_probe_ok();
        nlog = 0; absent_mode = 0;
        pulse(0, 0, 1);
        wait_done("probe");
        chk("R6 count", nlog, 4);
        chk("R6 resync op", lop[0], 3);
        chk("R6 pattern op", lop[1], 1);
        chk("R6 pattern addr", laddr[1], 0);
        chk("R6 pattern data", ldata[1], 8'h33);
        chk("R6 readback op", lop[2], 0);
        chk("R6 readback addr", laddr[2], 0);
        chk("R6 status addr", laddr[3], 8);
        chk("R6 status data", ldata[3], 0);
        chk("R6 present", int'(absent), 0);
        done_gone("probe");
    endtask

    task automatic t_set();
        int exp_d [7] = '{8'h45, 8'h07, 8'h23, 8'h31, 8'h12, 8'h06, 8'h24};
        nlog = 0;
        sec_i = 45; min_i = 7; hour_i = 23; mday_i = 31; mon_i = 11; wday_i = 6; year_i = 124;
        pulse(0, 1, 0);
        sec_i = 12; year_i = 150;               // changed after acceptance: R4
        repeat (3) @(negedge clk);
        chk("R8 busy during set", int'(busy), 1);
        get_req = 1;                            // arrives while busy: R8
        @(negedge clk);
        get_req = 0;
        wait_done("set");
        chk("R2 count", nlog, 8);
        for (int k = 0; k < 7; k++) begin
            chk($sformatf("R2 write op %0d", k), lop[k], 1);
            chk($sformatf("R2 write addr %0d", k), laddr[k], k);
            chk($sformatf("R4 write data %0d", k), ldata[k], exp_d[k]);
        end
        chk("R2 commit op", lop[7], 2);
        chk("R2 commit addr", laddr[7], 4'hF);
        chk("R2 clock month", int'(rclk[4]), 8'h12);
        chk("R4 clock year", int'(rclk[6]), 8'h24);
        chk("R5 no err on clean set", int'(cerr), 0);
        done_gone("set");
        repeat (10) @(negedge clk);
        chk("R8 busy request ignored busy", int'(busy), 0);
        chk("R8 busy request ignored log", nlog, 8);
    endtask

    task automatic t_get();
        nlog = 0;
        rclk = '{8'h59, 8'h30, 8'h08, 8'h01, 8'h01, 8'h00, 8'h99};
        for (int i = 0; i < 7; i++) mem[i] = 8'h11;
        pulse(1, 0, 0);
        wait_done("get");
        chk("R1 count", nlog, 8);
        chk("R1 snapshot op", lop[0], 2);
        chk("R1 snapshot addr", laddr[0], 4'hE);
        for (int k = 1; k < 8; k++) begin
            chk($sformatf("R1 read op %0d", k), lop[k], 0);
            chk($sformatf("R1 read addr %0d", k), laddr[k], k - 1);
        end
        chk("R3 sec", int'(sec_o), 59);
        chk("R3 min", int'(min_o), 30);
        chk("R3 hour", int'(hour_o), 8);
        chk("R3 mday", int'(mday_o), 1);
        chk("R3 month minus one", int'(mon_o), 0);
        chk("R3 wday", int'(wday_o), 0);
        chk("R3 year plus base", int'(year_o), 199);
        chk("R5 no err on clean get", int'(cerr), 0);
        done_gone("get");
    endtask

    task automatic t_bad();
        rclk = '{8'h5A, 8'h10, 8'h00, 8'h15, 8'h1F, 8'h03, 8'h00};
        pulse(1, 0, 0);
        wait_done("bad get");
        chk("R5 raw sec", int'(sec_o), 8'h5A);
        chk("R5 raw month unadjusted", int'(mon_o), 8'h1F);
        chk("R5 good min alongside", int'(min_o), 10);
        chk("R3 year zero", int'(year_o), 100);
        chk("R5 err on bad read", int'(cerr), 1);
        nlog = 0;
        sec_i = 0; min_i = 150; hour_i = 1; mday_i = 2; mon_i = 0; wday_i = 1; year_i = 200;
        pulse(0, 1, 0);
        wait_done("bad set");
        chk("R5 raw minute written", ldata[1], 150);
        chk("R4 year 200 mod", ldata[6], 8'h00);
        chk("R4 month zero plus one", ldata[4], 8'h01);
        chk("R5 err on bad write", int'(cerr), 1);
        rclk = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07};
        pulse(1, 0, 0);
        wait_done("clean get");
        chk("R5 err cleared by next sequence", int'(cerr), 0);
    endtask

    task automatic t_priority();
        nlog = 0;
        pulse(1, 1, 0);
        wait_done("prio set");
        chk("R8 set beats get first op", lop[0], 1);
        chk("R8 set beats get count", nlog, 8);
        nlog = 0;
        pulse(1, 1, 1);
        wait_done("prio probe");
        chk("R8 probe first op", lop[0], 3);
        chk("R8 probe count", nlog, 4);
    endtask

    task automatic t_absent();
        nlog = 0; absent_mode = 1;
        mem[8] = 8'h5C;
        pulse(0, 0, 1);
        wait_done("absent");
        chk("R7 absent set", int'(absent), 1);
        chk("R7 no status write count", nlog, 3);
        chk("R7 status untouched", int'(mem[8]), 8'h5C);
        done_gone("absent");
        absent_mode = 0;
        pulse(0, 0, 1);
        wait_done("reprobe");
        chk("R6 absent cleared", int'(absent), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_probe_ok();
        t_set();
        t_get();
        t_bad();
        t_priority();
        t_absent();
        chk("R9 handshake fields stable", hs_bad, 0);
        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule